// File: doc/BRIEF.md
# Multi-mode watchdog interval timer

This block is a timer that counts ticks from an external prescaler and takes one of three actions when the count reaches its terminal value. It can act as a plain interval timer, raising a maskable interrupt and a pending flag on every period. It can also act as a watchdog that raises a non-maskable interrupt or a system reset request. Software controls it through one 8-bit control register. The run bit and the two mode bits in that register can only be set by writes, never cleared. Once the timer is started, only a hardware reset stops it.

Software services the watchdog by writing the run bit as 1 again. That write clears the counter and begins a new period. A 2-bit select input picks the period length. The block also guards the moment a watchdog mode is armed. If the interval flag is already pending when software writes a watchdog mode, a non-maskable interrupt follows that write at once.

Top module: `wdog_timer`

## Requirements
- R1: A synchronous reset makes the register read 0x00, stops the counter, clears the pending flag and leaves all three request outputs low.
- R2: The register reads back the run bit at bit 7 and the mode bits at bits 4 (upper) and 3 (lower). Every other bit reads 0, whatever was written.
- R3: Once the run bit is 1, a write with bit 7 at 0 neither stops the count nor shifts its schedule.
- R4: A write with bit 7 at 1 clears the counter in the write cycle, whether the timer was stopped or running. The next overflow is then one full period later.
- R5: Once a mode bit is 1, writing 0 to it leaves it at 1.
- R6: The period is 2^(8+2*period_sel) count ticks, so select values 0 to 3 give 256, 1024, 4096 and 16384 ticks. The first overflow after a restart is seen on the cycle one tick past the write plus one period.
- R7: The counter advances only on cycles where tick_en is high.
- R8: With mode bit 4 at 0, an overflow sets the pending flag and raises irq for exactly one cycle. The count then wraps and repeats.
- R9: With mode bits 4,3 at 1,0, an overflow raises nmi for one cycle. It does not raise irq and does not change the pending flag.
- R10: With mode bits 4,3 at 1,1, an overflow raises rst_req for one cycle.
- R11: A write with bit 4 at 1 while the pending flag is 1 raises nmi on the cycle right after the write.
- R12: The pending flag stays set until flag_clr is high. If an interval overflow and flag_clr happen in the same cycle, the flag ends up set.
- R13: While the run bit is 0, no request output ever goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| tick_en | input | 1 | Count enable from the prescaler |
| period_sel | input | 2 | Period select |
| flag_clr | input | 1 | Clears the pending flag |
| flag | output | 1 | Pending interval flag |
| irq | output | 1 | Maskable interrupt pulse |
| nmi | output | 1 | Non-maskable interrupt pulse |
| rst_req | output | 1 | System reset request pulse |

## Verification
The immediate non-maskable interrupt is the hardest case to reach from the ports. It needs the pending flag left set from an earlier interval overflow, followed by a write that turns on a watchdog mode. The mode bits cannot be cleared, so that write is a one-way step. The stimulus therefore runs every interval-mode case first, including the long periods, the counting stall and the set-versus-clear collision on the flag. It then arms the watchdog with the flag still pending and checks that the immediate pulse and the later overflow pulse arrive on their predicted cycles. It ends by setting the last mode bit to reach the reset-request action, which leads into a hardware reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W    = 8;
    localparam int RUN_BIT  = 7;
    localparam int MODE_HI  = 4;
    localparam int MODE_LO  = 3;

    localparam logic [REG_W-1:0] SET_MASK =
        REG_W'((1 << RUN_BIT) | (1 << MODE_HI) | (1 << MODE_LO));

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_IRQ  = 2'd1,
        EV_NMI  = 2'd2,
        EV_RST  = 2'd3
    } evt_e;

    typedef struct packed {
        logic       run;
        logic [1:0] mode;
    } ctrl_t;

    function automatic evt_e route_overflow(input logic [1:0] mode);
        if (!mode[1])     return EV_IRQ;
        else if (!mode[0]) return EV_NMI;
        else              return EV_RST;
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output ctrl_t            ctrl,
    output logic             restart,
    output logic             arm_wd
);

    logic [REG_W-1:0] bits_q;
    logic [REG_W-1:0] wr_bits;

    assign wr_bits = wr_data & SET_MASK;

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else if (wr_en)
            bits_q <= bits_q | wr_bits;
    end

    assign rd_data   = bits_q;
    assign ctrl.run  = bits_q[RUN_BIT];
    assign ctrl.mode = {bits_q[MODE_HI], bits_q[MODE_LO]};
    assign restart   = wr_en & wr_bits[RUN_BIT];
    assign arm_wd    = wr_en & wr_bits[MODE_HI];

    assert_run_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> ctrl.run);
    assert_mode_hi_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mode[1] |=> ctrl.mode[1]);
    assert_mode_lo_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mode[0] |=> ctrl.mode[0]);
    assert_start_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> ctrl.run);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int BASE_LOG = 8,
    parameter int STEP     = 2,
    parameter int SEL_W    = 2,
    localparam int NSEL    = 1 << SEL_W,
    localparam int CW      = BASE_LOG + STEP * (NSEL - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] term_m1;
    int            shift_amt;

    always_comb begin
        shift_amt = BASE_LOG + STEP * int'(sel);
        term_m1   = CW'((64'd1 << shift_amt) - 64'd1);
    end

    assign ovf = run && tick && !restart && (cnt_q >= term_m1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= ovf ? '0 : cnt_q + 1'b1;
    end

    assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt_q));
    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));
    assert_wrap_after_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == '0));
    assert_idle_no_ovf_R13: assert property (@(posedge clk) disable iff (rst)
        !run |-> !ovf);

endmodule

// File: rtl/wdt_events.sv
module wdt_events
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ovf,
    input  logic [1:0] mode,
    input  logic       arm_wd,
    input  logic       flag_clr,
    output logic       flag,
    output logic       irq,
    output logic       nmi,
    output logic       rst_req
);

    evt_e evt;

    assign evt = ovf ? route_overflow(mode) : EV_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            irq     <= 1'b0;
            nmi     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (evt == EV_IRQ)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
            irq     <= (evt == EV_IRQ);
            nmi     <= (evt == EV_NMI) || (arm_wd && flag);
            rst_req <= (evt == EV_RST);
        end
    end

    assert_flag_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
    assert_irq_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    assert_arm_nmi_R11: assert property (@(posedge clk) disable iff (rst)
        (arm_wd && flag) |=> nmi);
    assert_rst_single_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int BASE_LOG = 8,
    parameter int STEP     = 2,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             flag_clr,
    output logic             flag,
    output logic             irq,
    output logic             nmi,
    output logic             rst_req
);

    ctrl_t ctrl;
    logic  restart;
    logic  arm_wd;
    logic  ovf;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .restart (restart),
        .arm_wd  (arm_wd)
    );

    wdt_counter #(
        .BASE_LOG (BASE_LOG),
        .STEP     (STEP),
        .SEL_W    (SEL_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (restart),
        .tick    (tick_en),
        .sel     (period_sel),
        .ovf     (ovf)
    );

    wdt_events u_evt (
        .clk      (clk),
        .rst      (rst),
        .ovf      (ovf),
        .mode     (ctrl.mode),
        .arm_wd   (arm_wd),
        .flag_clr (flag_clr),
        .flag     (flag),
        .irq      (irq),
        .nmi      (nmi),
        .rst_req  (rst_req)
    );

    assert_no_ovf_stopped_R13: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !(irq || rst_req));

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick_en = 1'b1;
    logic [1:0] period_sel = 2'd0;
    logic       flag_clr = 1'b0;
    logic       flag, irq, nmi, rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { int kind; int at; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_en(tick_en), .period_sel(period_sel),
        .flag_clr(flag_clr), .flag(flag), .irq(irq), .nmi(nmi),
        .rst_req(rst_req)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_evt(input int kind, input int at);
        exp_t e;
        e.kind = kind;
        e.at = at;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: compares observed pulses against the scoreboard (kind 1 irq R8, 2 nmi R9/R11, 3 rst R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R6 missing event: actual none expected kind %0d at cycle %0d", sb[0].kind, sb[0].at);
                void'(sb.pop_front());
            end
            if (irq || nmi || rst_req) begin
                int k;
                k = irq ? 1 : (nmi ? 2 : 3);
                n_cmp++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R13 unexpected event: actual kind %0d at %0d expected none", k, cyc);
                end else begin
                    if (sb[0].kind != k || sb[0].at != cyc || (irq + nmi + rst_req) != 1) begin
                        n_bad++;
                        $display("FAIL R8/R9/R10 event: actual kind %0d at %0d expected kind %0d at %0d",
                                 k, cyc, sb[0].kind, sb[0].at);
                    end
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(rd_data, 8'h00, "R1 rd_data");
        check(flag, 0, "R1 flag");
        check({irq, nmi, rst_req}, 0, "R1 outputs");
        // R13: stopped timer produces nothing
        wait_until(cyc + 300);

        // R8 interval mode, R2 readback, R3 run sticky
        c = cyc;
        expect_evt(1, c + 257);
        expect_evt(1, c + 513);
        wr(8'h80);
        wait_until(c + 100);
        wr(8'h67);
        check(rd_data, 8'h80, "R2 readback after 0x67");
        wait_until(c + 514);
        check(flag, 1, "R8 flag set");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(flag, 0, "R12 flag cleared");

        // R4 restart while running; R12 set wins over clear
        wait_until(c + 600);
        c = cyc;
        expect_evt(1, c + 257);
        wr(8'h80);
        wait_until(c + 256);
        flag_clr = 1'b1;
        @(negedge clk);
        check(flag, 1, "R12 set beats clear");
        flag_clr = 1'b0;

        // R7 counting stalls without tick_en
        @(negedge clk);
        c = cyc;
        tick_en = 1'b0;
        expect_evt(1, c + 306);
        wr(8'h80);
        repeat (49) @(negedge clk);
        tick_en = 1'b1;
        wait_until(c + 310);

        // R6 period select
        for (int s = 1; s < 4; s++) begin
            c = cyc;
            period_sel = 2'(s);
            expect_evt(1, c + 1 + (1 << (8 + 2 * s)));
            wr(8'h80);
            wait_until(c + 4 + (1 << (8 + 2 * s)));
        end
        period_sel = 2'd0;

        // R11 arming watchdog with flag pending; R9 flag untouched
        check(flag, 1, "R11 flag pending before arm");
        c = cyc;
        expect_evt(2, c + 1);
        expect_evt(2, c + 257);
        wr(8'h90);
        wait_until(c + 260);
        check(flag, 1, "R9 flag unchanged by nmi");
        check(rd_data, 8'h90, "R2 readback 0x90");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // R5 mode stays set after writing 0 to bit 4
        c = cyc;
        expect_evt(2, c + 257);
        wr(8'h80);
        check(rd_data, 8'h90, "R5 mode bit4 sticky");
        wait_until(c + 300);
        check(flag, 0, "R9 flag stays clear");

        // R10 reset mode (no restart: bit 7 not written)
        expect_evt(3, c + 513);
        wr(8'h08);
        check(rd_data, 8'h98, "R5 R10 readback 0x98");
        wait_until(c + 515);

        // R1 hardware reset again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(rd_data, 8'h00, "R1 rd_data after reset");
        check(flag, 0, "R1 flag after reset");
        wait_until(cyc + 300);

        done = 1;
        check(sb.size(), 0, "R6 scoreboard drained");
        finish_run();
    end

endmodule